// File: doc/BRIEF.md
# Audio Master, Bit and Frame Clock Generator

This block derives the three clocks of a serial audio port from one fast reference. The reference input runs at twice the source rate of the selected family: the source is either 512 or 384 times the sample rate fs, so one frame lasts 1024 or 768 reference cycles. Working from twice the source rate lets a source-rate master clock come from a flop. From this reference the block produces a master clock whose ratio to fs is set by a small code. It also produces a bit clock with 32 or 48 bits per frame, and a frame clock at fs.

A family select, a ratio code and a bits-per-frame select are sampled as one request. The request is accepted only if it is legal. While the generator runs, it takes effect only at a frame boundary, so no output pulse is ever cut short. A run input starts and stops the generator. A clock-gate input and a soft-reset input each freeze the whole state and hold every output low until released.

Top module: `mclk_gen`

## Requirements
- R1: With `fam384`=0 (512fs family), ratio codes 0 to 4 give a master clock of (512 >> code)·fs, i.e. a period of 2^(code+1) reference cycles.
- R2: With `fam384`=1 (384fs family), ratio codes 0 to 3 give a master clock of (384 >> code)·fs, i.e. a period of 2^(code+1) reference cycles.
- R3: A request with a code above 4 in the 512fs family or above 3 in the 384fs family is rejected as a whole, and the previous family, code and bit setting stay in force.
- R4: The bit clock period is one frame divided by the bits per frame. With `bits48`=0 there are 32 bits per frame. With `bits48`=1 in the 384fs family there are 48 bits per frame, a period of 16 reference cycles.
- R5: In the 512fs family `bits48` has no effect, and the bit clock keeps a period of 32 reference cycles.
- R6: The frame clock has a period of one frame (1024 or 768 reference cycles). It is low for the first half of the frame and high for the second half, and it rises while the bit clock is low.
- R7: From the first reference edge with `run` low, all three outputs are low and the frame restarts. After `run` returns high, the frame clock first rises half a frame later.
- R8: While `clk_gate` or `soft_rst` is high, all outputs are low at once and the internal phase is frozen. On release, counting resumes from the frozen phase.
- R9: A request made while running takes effect only at the next frame boundary. A request made while stopped takes effect at the next edge.
- R10: After reset, all outputs are low and the 512fs family with code 0 and 32 bits per frame is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, twice the source rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset: freeze state, outputs low |
| clk_gate | input | 1 | Clock gate: freeze state, outputs low |
| run | input | 1 | Generator enable |
| fam384 | input | 1 | Source family: 0 = 512fs, 1 = 384fs |
| ratio_code | input | 3 | Master clock ratio code |
| bits48 | input | 1 | 48 bits per frame when set (384fs family only) |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame (left/right) clock |

## Verification
The bench builds the block with its default parameters: 512fs and 384fs families, 32 and 48 bits per frame, and combinational output gating. These values put every legal code of both families within reach, along with the 12-cycle bit-clock half period that is not a power of two. A queue-based scoreboard measures master-clock, bit-clock and frame-clock periods and the frame high time for every legal code, for rejected codes and for the bit-select variants. Directed sequences cover a mid-frame code change, a stop and restart, and a freeze by the gate and by soft reset, where the remaining frame time shows whether the phase was held.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
   localparam int unsigned CODE_W = 3;

   typedef struct packed {
      logic              fam384;
      logic              wide;
      logic [CODE_W-1:0] code;
   } mcg_cfg_t;
endpackage

// File: rtl/mcg_cfg_latch.sv
module mcg_cfg_latch
   import mcg_pkg::*;
#(
   parameter int unsigned HI_MAX = 4,
   parameter int unsigned LO_MAX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              req_fam384,
   input  logic              req_wide,
   input  logic [CODE_W-1:0] req_code,
   output mcg_cfg_t          cfg_q
);
   localparam logic [CODE_W-1:0] HI_MAX_C = CODE_W'(HI_MAX);
   localparam logic [CODE_W-1:0] LO_MAX_C = CODE_W'(LO_MAX);

   logic legal;
   assign legal = req_fam384 ? (req_code <= LO_MAX_C) : (req_code <= HI_MAX_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (load && legal) begin
         cfg_q.fam384 <= req_fam384;
         cfg_q.wide   <= req_wide & req_fam384;
         cfg_q.code   <= req_code;
      end
   end
endmodule

// File: rtl/mcg_phase.sv
module mcg_phase #(
   parameter int unsigned FRAME_HI = 1024,
   parameter int unsigned FRAME_LO = 768,
   parameter int unsigned PH_W     = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt,
   input  logic            run,
   input  logic            fam384,
   output logic [PH_W-1:0] ph_q,
   output logic            wrap
);
   localparam logic [PH_W-1:0] LAST_HI = PH_W'(FRAME_HI - 1);
   localparam logic [PH_W-1:0] LAST_LO = PH_W'(FRAME_LO - 1);

   assign wrap = run && (ph_q == (fam384 ? LAST_LO : LAST_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ph_q <= '0;
      else if (halt)        ph_q <= ph_q;
      else if (!run || wrap) ph_q <= '0;
      else                  ph_q <= ph_q + 1'b1;
   end
endmodule

// File: rtl/mcg_bitclk.sv
module mcg_bitclk #(
   parameter int unsigned HALF_HI  = 16,
   parameter int unsigned HALF_LON = 12,
   parameter int unsigned HALF_LOW = 8,
   parameter int unsigned HC_W     = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt,
   input  logic run,
   input  logic wrap,
   input  logic fam384,
   input  logic wide,
   output logic bclk_q
);
   localparam logic [HC_W-1:0] END_HI  = HC_W'(HALF_HI - 1);
   localparam logic [HC_W-1:0] END_LON = HC_W'(HALF_LON - 1);
   localparam logic [HC_W-1:0] END_LOW = HC_W'(HALF_LOW - 1);

   logic [HC_W-1:0] hc_q;
   logic [HC_W-1:0] hc_end;

   assign hc_end = !fam384 ? END_HI : (wide ? END_LOW : END_LON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc_q   <= '0;
         bclk_q <= 1'b0;
      end else if (halt) begin
         hc_q   <= hc_q;
         bclk_q <= bclk_q;
      end else if (!run || wrap) begin
         hc_q   <= '0;
         bclk_q <= 1'b0;
      end else if (hc_q == hc_end) begin
         hc_q   <= '0;
         bclk_q <= ~bclk_q;
      end else begin
         hc_q   <= hc_q + 1'b1;
      end
   end
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
   import mcg_pkg::*;
#(
   parameter int unsigned SRC_HI_FS  = 512,
   parameter int unsigned SRC_LO_FS  = 384,
   parameter int unsigned BITS_N     = 32,
   parameter int unsigned BITS_W     = 48,
   parameter bit          OUT_RETIME = 1'b0
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              clk_gate,
   input  logic              run,
   input  logic              fam384,
   input  logic [CODE_W-1:0] ratio_code,
   input  logic              bits48,
   output logic              mclk_o,
   output logic              bclk_o,
   output logic              fs_o
);
   localparam int unsigned FRAME_HI = 2 * SRC_HI_FS;
   localparam int unsigned FRAME_LO = 2 * SRC_LO_FS;
   localparam int unsigned PH_W     = $clog2(FRAME_HI);
   localparam int unsigned HI_MAX   = $clog2(SRC_HI_FS / BITS_N);
   localparam int unsigned LO_MAX   = $clog2(SRC_LO_FS / BITS_W);
   localparam int unsigned HALF_HI  = FRAME_HI / (2 * BITS_N);
   localparam int unsigned HALF_LON = FRAME_LO / (2 * BITS_N);
   localparam int unsigned HALF_LOW = FRAME_LO / (2 * BITS_W);
   localparam int unsigned HC_W     = $clog2(HALF_HI + 1);
   localparam logic [PH_W-1:0] MID_HI = PH_W'(FRAME_HI / 2);
   localparam logic [PH_W-1:0] MID_LO = PH_W'(FRAME_LO / 2);

   if (SRC_LO_FS >= SRC_HI_FS) begin : g_bad_order
      $error("low family must be slower than high family");
   end
   if ((BITS_N << HI_MAX) != SRC_HI_FS || (BITS_W << LO_MAX) != SRC_LO_FS) begin : g_bad_ratio
      $error("family rates must be power-of-two multiples of the bit counts");
   end
   if ((FRAME_LO % (2 * BITS_N)) != 0 || (FRAME_LO % (2 * BITS_W)) != 0 ||
       (FRAME_HI % (2 * BITS_N)) != 0) begin : g_bad_half
      $error("bit clock half period must be a whole number of cycles");
   end
   if (HI_MAX >= (1 << CODE_W) || HI_MAX >= PH_W) begin : g_bad_code
      $error("ratio code field too narrow");
   end

   logic            halt;
   logic            wrap;
   logic            load;
   logic [PH_W-1:0] ph_q;
   logic            bclk_q;
   mcg_cfg_t        cfg_q;
   logic            mclk_c, bclk_c, fs_c;

   assign halt = soft_rst | clk_gate;
   assign load = !halt && (!run || wrap);

   mcg_cfg_latch #(.HI_MAX(HI_MAX), .LO_MAX(LO_MAX)) u_cfg (
      .clk(ref_clk), .rst_n(rst_n), .load(load),
      .req_fam384(fam384), .req_wide(bits48), .req_code(ratio_code),
      .cfg_q(cfg_q)
   );

   mcg_phase #(.FRAME_HI(FRAME_HI), .FRAME_LO(FRAME_LO), .PH_W(PH_W)) u_ph (
      .clk(ref_clk), .rst_n(rst_n), .halt(halt), .run(run),
      .fam384(cfg_q.fam384), .ph_q(ph_q), .wrap(wrap)
   );

   mcg_bitclk #(.HALF_HI(HALF_HI), .HALF_LON(HALF_LON), .HALF_LOW(HALF_LOW),
                .HC_W(HC_W)) u_bclk (
      .clk(ref_clk), .rst_n(rst_n), .halt(halt), .run(run), .wrap(wrap),
      .fam384(cfg_q.fam384), .wide(cfg_q.wide), .bclk_q(bclk_q)
   );

   assign mclk_c = ph_q[cfg_q.code] & ~halt;
   assign bclk_c = bclk_q & ~halt;
   assign fs_c   = (ph_q >= (cfg_q.fam384 ? MID_LO : MID_HI)) & ~halt;

   if (OUT_RETIME) begin : g_out_reg
      always_ff @(posedge ref_clk or negedge rst_n) begin
         if (!rst_n) begin
            mclk_o <= 1'b0;
            bclk_o <= 1'b0;
            fs_o   <= 1'b0;
         end else begin
            mclk_o <= mclk_c;
            bclk_o <= bclk_c;
            fs_o   <= fs_c;
         end
      end
   end else begin : g_out_comb
      assign mclk_o = mclk_c;
      assign bclk_o = bclk_c;
      assign fs_o   = fs_c;
   end
endmodule

// File: rtl/mcg_checker.sv
module mcg_checker
   import mcg_pkg::*;
#(
   parameter int unsigned PH_W   = 10,
   parameter int unsigned HI_MAX = 4,
   parameter int unsigned LO_MAX = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            run,
   input logic            soft_rst,
   input logic            clk_gate,
   input logic            mclk_o,
   input logic            bclk_o,
   input logic            fs_o,
   input logic [PH_W-1:0] ph_q,
   input logic            wrap,
   input mcg_cfg_t        cfg_q
);
   logic halt;
   assign halt = soft_rst | clk_gate;

   // R3
   cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.fam384 ? (32'(cfg_q.code) <= LO_MAX) : (32'(cfg_q.code) <= HI_MAX));

   // R9
   cfg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q != $past(cfg_q)) |-> ($past(wrap) || !$past(run)));

   // R8
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(halt) |-> (ph_q == $past(ph_q)));

   // R7
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run) && !$past(run, 2) && !$past(halt) && !$past(halt, 2))
      |-> (!mclk_o && !bclk_o && !fs_o));

   // R6
   fs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fs_o) && !$past(halt) && !halt) |-> !bclk_o);
endmodule

bind mclk_gen mcg_checker #(.PH_W(PH_W), .HI_MAX(HI_MAX), .LO_MAX(LO_MAX)) u_chk (
   .clk(ref_clk), .rst_n(rst_n), .run(run), .soft_rst(soft_rst),
   .clk_gate(clk_gate), .mclk_o(mclk_o), .bclk_o(bclk_o), .fs_o(fs_o),
   .ph_q(ph_q), .wrap(wrap), .cfg_q(cfg_q)
);

// File: tb/tb_mclk_gen.sv
module tb_mclk_gen;
   logic       ref_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0, clk_gate = 1'b0, run = 1'b0;
   logic       fam384 = 1'b0, bits48 = 1'b0;
   logic [2:0] ratio_code = 3'd0;
   logic       mclk_o, bclk_o, fs_o;

   int n_chk = 0, n_bad = 0;
   bit busy = 1'b0;
   bit acc_fam = 1'b0, acc_wide = 1'b0;
   int acc_code = 0;

   typedef struct {
      string tag;
      int mper, bper, fper, fhi;
   } exp_t;
   exp_t exp_q[$];

   always #2 ref_clk = ~ref_clk;

   mclk_gen dut (
      .ref_clk(ref_clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_gate(clk_gate),
      .run(run), .fam384(fam384), .ratio_code(ratio_code), .bits48(bits48),
      .mclk_o(mclk_o), .bclk_o(bclk_o), .fs_o(fs_o)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s actual %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic logic pick(input int sel);
      case (sel)
         0: return mclk_o;
         1: return bclk_o;
         default: return fs_o;
      endcase
   endfunction

   task automatic meas(input int sel, output int per, output int hi);
      logic prev, cur;
      prev = pick(sel);
      forever begin
         @(negedge ref_clk);
         cur = pick(sel);
         if (!prev && cur) break;
         prev = cur;
      end
      per = 0; hi = 1; prev = 1'b1;
      forever begin
         @(negedge ref_clk);
         per++;
         cur = pick(sel);
         if (!prev && cur) break;
         if (cur) hi++;
         prev = cur;
      end
   endtask

   task automatic wait_level(input int sel, input logic val);
      logic prev, cur;
      prev = pick(sel);
      forever begin
         @(negedge ref_clk);
         cur = pick(sel);
         if (cur == val && prev != val) break;
         prev = cur;
      end
   endtask

   // driver: apply a request, track what must be in force, queue expectations
   task automatic request(input bit fam, input int code, input bit wide, input string tag);
      exp_t e;
      int frame, bits;
      @(negedge ref_clk);
      fam384 = fam; ratio_code = 3'(code); bits48 = wide;
      if (fam ? (code <= 3) : (code <= 4)) begin
         acc_fam = fam; acc_code = code; acc_wide = wide & fam;
      end
      frame = acc_fam ? 768 : 1024;
      bits  = acc_wide ? 48 : 32;
      e.tag = tag; e.mper = 2 << acc_code; e.bper = frame / bits;
      e.fper = frame; e.fhi = frame / 2;
      exp_q.push_back(e);
      do @(negedge ref_clk); while (exp_q.size() != 0 || busy);
   endtask

   // monitor / scoreboard
   initial begin
      exp_t e;
      int per, hi;
      forever begin
         @(negedge ref_clk);
         if (exp_q.size() > 0) begin
            busy = 1'b1;
            e = exp_q.pop_front();
            repeat (1100) @(negedge ref_clk);
            meas(0, per, hi); chk({e.tag, " mclk period"}, per, e.mper);
            meas(1, per, hi); chk({e.tag, " bclk period"}, per, e.bper);
            meas(2, per, hi); chk("R6 frame period", per, e.fper);
            chk("R6 frame high time", hi, e.fhi);
            busy = 1'b0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge ref_clk);
      n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int per, hi, cnt, bad;
      repeat (5) @(negedge ref_clk);
      chk("R10 mclk in reset", int'(mclk_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge ref_clk);
      chk("R10 outputs after reset", int'({mclk_o, bclk_o, fs_o}), 0);
      run = 1'b1;
      for (int c = 0; c <= 4; c++) request(1'b0, c, 1'b0, $sformatf("R1 code %0d", c));
      request(1'b0, 6, 1'b0, "R3 illegal 512 code 6");
      request(1'b0, 2, 1'b1, "R5 bits48 in 512 family");
      for (int c = 0; c <= 3; c++) request(1'b1, c, 1'b0, $sformatf("R2 code %0d", c));
      request(1'b1, 4, 1'b1, "R3 illegal 384 code 4");
      request(1'b1, 1, 1'b1, "R4 48 bits");
      request(1'b1, 1, 1'b0, "R4 32 bits in 384");
      request(1'b0, 0, 1'b0, "R1 back to code 0");

      // R9: mid-frame change waits for the boundary
      wait_level(2, 1'b1);
      fam384 = 1'b0; ratio_code = 3'd2; bits48 = 1'b0;
      meas(0, per, hi); chk("R9 old ratio kept mid-frame", per, 2);
      wait_level(2, 1'b0);
      repeat (4) @(negedge ref_clk);
      meas(0, per, hi); chk("R9 new ratio after boundary", per, 8);

      // R7: stop and restart
      @(negedge ref_clk);
      run = 1'b0;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge ref_clk);
         if (mclk_o || bclk_o || fs_o) bad++;
      end
      chk("R7 outputs low while stopped", bad, 0);
      run = 1'b1;
      cnt = 0;
      do begin @(negedge ref_clk); cnt++; end while (!fs_o);
      chk("R7 frame restarts on run", cnt, 512);

      // R8: freeze via clock gate, then via soft reset
      for (int k = 0; k < 2; k++) begin
         wait_level(2, 1'b1);
         repeat (100) @(negedge ref_clk);
         if (k == 0) clk_gate = 1'b1; else soft_rst = 1'b1;
         bad = 0;
         for (int i = 0; i < 50; i++) begin
            @(negedge ref_clk);
            if (mclk_o || bclk_o || fs_o) bad++;
         end
         chk("R8 outputs low while frozen", bad, 0);
         clk_gate = 1'b0; soft_rst = 1'b0;
         cnt = 0;
         do begin @(negedge ref_clk); cnt++; end while (fs_o);
         chk("R8 phase resumes where frozen", cnt, 412);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule